// File: doc/BRIEF.md
# AXI4-Lite Address-Decoding Bus Splitter

This block sits between one AXI4-Lite manager and a set of downstream register regions. It accepts requests on one upstream subordinate port and steers each one to a single child manager port. There are two kinds of target. A lone "solo" region sits at its own base. An array of equal-sized "tile" regions sits at a fixed stride above a second base. A request that falls in neither window gets a local decode-error response.

Writes and reads each have their own decoder and their own small state machine, so one of each can be in flight at the same time, possibly to different children. Each decoder subtracts the region base from the address. For array tiles it also subtracts the tile index times the stride. The result is cut to the bit width of the child's own window, so every child sees only its local offset. The protection field, write data and write strobe pass to the children unchanged. Only the selected child sees a valid.

The write machine has four states:
- **WS_IDLE**: moves to **WS_SEND** once both the address valid and the data valid are high. The decoded target is latched on that move.
- **WS_SEND**: moves to **WS_RESP** once both address and data handshakes have completed and the target is mapped. If the target is unmapped it moves to **WS_ERR** instead.
- **WS_RESP**: returns to **WS_IDLE** on the response handshake with the child.
- **WS_ERR**: returns to **WS_IDLE** on the local error-response handshake.

The read machine mirrors this with **RS_IDLE**, **RS_SEND**, **RS_RESP** and **RS_ERR**. It moves from RS_IDLE to RS_SEND on read-address valid and leaves RS_SEND after the read-address handshake.

Top module: `axil_split`

## Requirements
- R1: An address in [SOLO_BASE, SOLO_BASE+SOLO_SIZE) selects child 0. That child receives the address minus SOLO_BASE, cut to clog2(SOLO_SIZE) bits.
- R2: An address in [ARR_BASE+i*ARR_STRIDE, ARR_BASE+(i+1)*ARR_STRIDE), for i from 0 to ARR_N-1, selects child i+1. That child receives the address minus ARR_BASE minus i*ARR_STRIDE, cut to clog2(ARR_STRIDE) bits. This holds at both the first and the last word of each tile.
- R3: The read address is decoded and rebased by the same rules as the write address, from the upstream read address. A write and a read may be in flight to different children at the same time.
- R4: The 3-bit write and read protection fields reach the child unchanged. Write data and write strobe reach the selected child together with its write-data valid.
- R5: At most one child's write-address valid and at most one child's read-address valid are high in any cycle. No child other than the decoded one ever sees a valid.
- R6: A child's address and data valids first rise one cycle after the upstream request is first seen. While they are high, upstream address ready and data ready follow the selected child's ready, so a child that holds ready low stalls the upstream handshake.
- R7: The selected child's write response (2-bit code) is returned upstream. Its read response (data and 2-bit code) is returned upstream too. Response ready goes only to the child that owns the transaction.
- R8: A write or read to an unmapped address completes without any child seeing a valid. It returns the response code 2'b11, and the read data is zero.
- R9: Only one write and one read may be outstanding. While a write response is pending, upstream write-address ready and write-data ready stay low. While a read response is pending, read-address ready stays low.
- R10: During and right after reset, all upstream readies and response valids are low, and all child valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_awvalid | input | 1 | Upstream write-address valid |
| up_awready | output | 1 | Upstream write-address ready |
| up_awaddr | input | AW | Upstream write address |
| up_awprot | input | 3 | Upstream write protection |
| up_wvalid | input | 1 | Upstream write-data valid |
| up_wready | output | 1 | Upstream write-data ready |
| up_wdata | input | DW | Upstream write data |
| up_wstrb | input | DW/8 | Upstream write strobe |
| up_bvalid | output | 1 | Upstream write-response valid |
| up_bready | input | 1 | Upstream write-response ready |
| up_bresp | output | 2 | Upstream write-response code |
| up_arvalid | input | 1 | Upstream read-address valid |
| up_arready | output | 1 | Upstream read-address ready |
| up_araddr | input | AW | Upstream read address |
| up_arprot | input | 3 | Upstream read protection |
| up_rvalid | output | 1 | Upstream read-data valid |
| up_rready | input | 1 | Upstream read-data ready |
| up_rdata | output | DW | Upstream read data |
| up_rresp | output | 2 | Upstream read-response code |
| dn_awvalid | output | ARR_N+1 | Per-child write-address valid (bit 0 solo, bit i+1 tile i) |
| dn_awready | input | ARR_N+1 | Per-child write-address ready |
| solo_awaddr | output | clog2(SOLO_SIZE) | Rebased write address for the solo child |
| tile_awaddr | output | ARR_N*clog2(ARR_STRIDE) | Rebased write address for each tile, tile i in slice i |
| dn_awprot | output | 3 | Write protection shared by all children |
| dn_wvalid | output | ARR_N+1 | Per-child write-data valid |
| dn_wready | input | ARR_N+1 | Per-child write-data ready |
| dn_wdata | output | DW | Write data shared by all children |
| dn_wstrb | output | DW/8 | Write strobe shared by all children |
| dn_bvalid | input | ARR_N+1 | Per-child write-response valid |
| dn_bready | output | ARR_N+1 | Per-child write-response ready |
| dn_bresp | input | 2*(ARR_N+1) | Per-child write-response code |
| dn_arvalid | output | ARR_N+1 | Per-child read-address valid |
| dn_arready | input | ARR_N+1 | Per-child read-address ready |
| solo_araddr | output | clog2(SOLO_SIZE) | Rebased read address for the solo child |
| tile_araddr | output | ARR_N*clog2(ARR_STRIDE) | Rebased read address for each tile |
| dn_arprot | output | 3 | Read protection shared by all children |
| dn_rvalid | input | ARR_N+1 | Per-child read-data valid |
| dn_rready | output | ARR_N+1 | Per-child read-data ready |
| dn_rdata | input | DW*(ARR_N+1) | Per-child read data |
| dn_rresp | input | 2*(ARR_N+1) | Per-child read-response code |

## Verification
Some properties are checked by the in-module assertions on every cycle:
- only one child address valid and one response ready per direction;
- upstream readies follow the selected child's ready while a valid is driven;
- no new request is accepted while a response is pending;
- an unmapped request produces the decode-error response, with zero read data.

Other behaviour is shown only by the bench's scenarios, where the bench computes the target and offset itself:
- correct rebasing at the edges of each tile;
- the one-cycle delay before a child sees a valid;
- a child stall holding off the upstream handshake;
- concurrent write and read to different children;
- returned response codes and data.

// File: rtl/axil_split_pkg.sv
package axil_split_pkg;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_SEND,
        WS_RESP,
        WS_ERR
    } wr_state_e;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_SEND,
        RS_RESP,
        RS_ERR
    } rd_state_e;

    localparam logic [1:0] RESP_DECERR = 2'b11;

endpackage

// File: rtl/axil_split_decode.sv
module axil_split_decode #(
    parameter int          AW         = 16,
    parameter int unsigned SOLO_BASE  = 32'h1000,
    parameter int unsigned SOLO_SIZE  = 256,
    parameter int unsigned ARR_BASE   = 32'h2000,
    parameter int unsigned ARR_STRIDE = 64,
    parameter int          ARR_N      = 4,
    parameter int          IW         = $clog2(ARR_N + 2),
    parameter int          SOLO_AW    = $clog2(SOLO_SIZE),
    parameter int          ARR_AW     = $clog2(ARR_STRIDE)
) (
    input  logic [AW-1:0]           addr,
    output logic [IW-1:0]           hit_idx,
    output logic [SOLO_AW-1:0]      solo_addr,
    output logic [ARR_N*ARR_AW-1:0] tile_addr
);
    localparam int NC = ARR_N + 1;

    logic [AW-1:0] solo_off;
    logic [AW-1:0] arr_off;

    assign solo_off  = addr - AW'(SOLO_BASE);
    assign arr_off   = addr - AW'(ARR_BASE);
    assign solo_addr = SOLO_AW'(solo_off);

    // each tile gets its own offset: base and index*stride removed
    for (genvar i = 0; i < ARR_N; i++) begin : g_tile
        assign tile_addr[i*ARR_AW +: ARR_AW] =
            ARR_AW'(addr - AW'(ARR_BASE) - AW'(i * ARR_STRIDE));
    end

    // index NC encodes "no child"; solo window wins if windows overlapped
    always_comb begin
        hit_idx = IW'(NC);
        if (addr >= AW'(SOLO_BASE) && solo_off < AW'(SOLO_SIZE)) begin
            hit_idx = '0;
        end else if (addr >= AW'(ARR_BASE) && arr_off < AW'(ARR_N * ARR_STRIDE)) begin
            hit_idx = IW'(arr_off >> ARR_AW) + IW'(1);
        end
    end

endmodule

// File: rtl/axil_split_wr.sv
module axil_split_wr
    import axil_split_pkg::*;
#(
    parameter int NC = 5,
    parameter int IW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           up_awvalid,
    output logic           up_awready,
    input  logic           up_wvalid,
    output logic           up_wready,
    output logic           up_bvalid,
    input  logic           up_bready,
    output logic [1:0]     up_bresp,
    input  logic [IW-1:0]  hit_idx,
    output logic [NC-1:0]  dn_awvalid,
    input  logic [NC-1:0]  dn_awready,
    output logic [NC-1:0]  dn_wvalid,
    input  logic [NC-1:0]  dn_wready,
    input  logic [NC-1:0]  dn_bvalid,
    output logic [NC-1:0]  dn_bready,
    input  logic [2*NC-1:0] dn_bresp
);
    wr_state_e     st, st_nx;
    logic [IW-1:0] tgt;
    logic          aw_done, w_done;
    logic          miss, aw_hs, w_hs;

    assign miss  = (tgt == IW'(NC));
    assign aw_hs = up_awvalid & up_awready;
    assign w_hs  = up_wvalid & up_wready;

    always_comb begin
        st_nx = st;
        unique case (st)
            WS_IDLE: if (up_awvalid && up_wvalid) st_nx = WS_SEND;
            WS_SEND: if ((aw_done || aw_hs) && (w_done || w_hs))
                         st_nx = miss ? WS_ERR : WS_RESP;
            WS_RESP, WS_ERR: if (up_bvalid && up_bready) st_nx = WS_IDLE;
            default: st_nx = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= WS_IDLE;
            tgt     <= IW'(NC);
            aw_done <= 1'b0;
            w_done  <= 1'b0;
        end else begin
            st <= st_nx;
            if (st == WS_IDLE && st_nx == WS_SEND) tgt <= hit_idx;
            if (st == WS_SEND) begin
                aw_done <= aw_done | aw_hs;
                w_done  <= w_done | w_hs;
            end else begin
                aw_done <= 1'b0;
                w_done  <= 1'b0;
            end
        end
    end

    always_comb begin
        up_awready = 1'b0;
        up_wready  = 1'b0;
        up_bvalid  = 1'b0;
        up_bresp   = '0;
        dn_awvalid = '0;
        dn_wvalid  = '0;
        dn_bready  = '0;
        unique case (st)
            WS_SEND: begin
                if (miss) begin
                    up_awready = ~aw_done;
                    up_wready  = ~w_done;
                end else begin
                    for (int c = 0; c < NC; c++) begin
                        if (tgt == IW'(c)) begin
                            dn_awvalid[c] = up_awvalid & ~aw_done;
                            dn_wvalid[c]  = up_wvalid & ~w_done;
                            up_awready    = dn_awready[c] & ~aw_done;
                            up_wready     = dn_wready[c] & ~w_done;
                        end
                    end
                end
            end
            WS_RESP: begin
                for (int c = 0; c < NC; c++) begin
                    if (tgt == IW'(c)) begin
                        up_bvalid    = dn_bvalid[c];
                        up_bresp     = dn_bresp[2*c +: 2];
                        dn_bready[c] = up_bready;
                    end
                end
            end
            WS_ERR: begin
                up_bvalid = 1'b1;
                up_bresp  = RESP_DECERR;
            end
            default: ;
        endcase
    end

    a_r5_aw_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dn_awvalid));
    a_r7_bready_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dn_bready));
    a_r9_no_write_accept_in_resp: assert property (@(posedge clk) disable iff (!rst_n)
        up_bvalid |-> (!up_awready && !up_wready));
    a_r6_aw_ready_follows_child: assert property (@(posedge clk) disable iff (!rst_n)
        (|dn_awvalid) |-> (up_awready == |(dn_awvalid & dn_awready)));
    a_r8_write_decerr: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WS_SEND && st_nx == WS_ERR) |=>
            (up_bvalid && up_bresp == RESP_DECERR && dn_awvalid == '0));

endmodule

// File: rtl/axil_split_rd.sv
module axil_split_rd
    import axil_split_pkg::*;
#(
    parameter int NC = 5,
    parameter int IW = 3,
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_arvalid,
    output logic             up_arready,
    output logic             up_rvalid,
    input  logic             up_rready,
    output logic [DW-1:0]    up_rdata,
    output logic [1:0]       up_rresp,
    input  logic [IW-1:0]    hit_idx,
    output logic [NC-1:0]    dn_arvalid,
    input  logic [NC-1:0]    dn_arready,
    input  logic [NC-1:0]    dn_rvalid,
    output logic [NC-1:0]    dn_rready,
    input  logic [NC*DW-1:0] dn_rdata,
    input  logic [2*NC-1:0]  dn_rresp
);
    rd_state_e     st, st_nx;
    logic [IW-1:0] tgt;
    logic          miss, ar_hs;

    assign miss  = (tgt == IW'(NC));
    assign ar_hs = up_arvalid & up_arready;

    always_comb begin
        st_nx = st;
        unique case (st)
            RS_IDLE: if (up_arvalid) st_nx = RS_SEND;
            RS_SEND: if (ar_hs) st_nx = miss ? RS_ERR : RS_RESP;
            RS_RESP, RS_ERR: if (up_rvalid && up_rready) st_nx = RS_IDLE;
            default: st_nx = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= RS_IDLE;
            tgt <= IW'(NC);
        end else begin
            st <= st_nx;
            if (st == RS_IDLE && st_nx == RS_SEND) tgt <= hit_idx;
        end
    end

    always_comb begin
        up_arready = 1'b0;
        up_rvalid  = 1'b0;
        up_rdata   = '0;
        up_rresp   = '0;
        dn_arvalid = '0;
        dn_rready  = '0;
        unique case (st)
            RS_SEND: begin
                if (miss) begin
                    up_arready = 1'b1;
                end else begin
                    for (int c = 0; c < NC; c++) begin
                        if (tgt == IW'(c)) begin
                            dn_arvalid[c] = up_arvalid;
                            up_arready    = dn_arready[c];
                        end
                    end
                end
            end
            RS_RESP: begin
                for (int c = 0; c < NC; c++) begin
                    if (tgt == IW'(c)) begin
                        up_rvalid    = dn_rvalid[c];
                        up_rdata     = dn_rdata[c*DW +: DW];
                        up_rresp     = dn_rresp[2*c +: 2];
                        dn_rready[c] = up_rready;
                    end
                end
            end
            RS_ERR: begin
                up_rvalid = 1'b1;
                up_rresp  = RESP_DECERR;
            end
            default: ;
        endcase
    end

    a_r5_ar_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dn_arvalid));
    a_r7_rready_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dn_rready));
    a_r9_no_read_accept_in_resp: assert property (@(posedge clk) disable iff (!rst_n)
        up_rvalid |-> !up_arready);
    a_r6_ar_ready_follows_child: assert property (@(posedge clk) disable iff (!rst_n)
        (|dn_arvalid) |-> (up_arready == |(dn_arvalid & dn_arready)));
    a_r8_read_decerr: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RS_SEND && st_nx == RS_ERR) |=>
            (up_rvalid && up_rresp == RESP_DECERR && up_rdata == '0));

endmodule

// File: rtl/axil_split.sv
module axil_split #(
    parameter int          AW         = 16,
    parameter int          DW         = 32,
    parameter int unsigned SOLO_BASE  = 32'h1000,
    parameter int unsigned SOLO_SIZE  = 256,
    parameter int unsigned ARR_BASE   = 32'h2000,
    parameter int unsigned ARR_STRIDE = 64,
    parameter int          ARR_N      = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 up_awvalid,
    output logic                                 up_awready,
    input  logic [AW-1:0]                        up_awaddr,
    input  logic [2:0]                           up_awprot,
    input  logic                                 up_wvalid,
    output logic                                 up_wready,
    input  logic [DW-1:0]                        up_wdata,
    input  logic [DW/8-1:0]                      up_wstrb,
    output logic                                 up_bvalid,
    input  logic                                 up_bready,
    output logic [1:0]                           up_bresp,
    input  logic                                 up_arvalid,
    output logic                                 up_arready,
    input  logic [AW-1:0]                        up_araddr,
    input  logic [2:0]                           up_arprot,
    output logic                                 up_rvalid,
    input  logic                                 up_rready,
    output logic [DW-1:0]                        up_rdata,
    output logic [1:0]                           up_rresp,
    output logic [ARR_N:0]                       dn_awvalid,
    input  logic [ARR_N:0]                       dn_awready,
    output logic [$clog2(SOLO_SIZE)-1:0]         solo_awaddr,
    output logic [ARR_N*$clog2(ARR_STRIDE)-1:0]  tile_awaddr,
    output logic [2:0]                           dn_awprot,
    output logic [ARR_N:0]                       dn_wvalid,
    input  logic [ARR_N:0]                       dn_wready,
    output logic [DW-1:0]                        dn_wdata,
    output logic [DW/8-1:0]                      dn_wstrb,
    input  logic [ARR_N:0]                       dn_bvalid,
    output logic [ARR_N:0]                       dn_bready,
    input  logic [2*ARR_N+1:0]                   dn_bresp,
    output logic [ARR_N:0]                       dn_arvalid,
    input  logic [ARR_N:0]                       dn_arready,
    output logic [$clog2(SOLO_SIZE)-1:0]         solo_araddr,
    output logic [ARR_N*$clog2(ARR_STRIDE)-1:0]  tile_araddr,
    output logic [2:0]                           dn_arprot,
    input  logic [ARR_N:0]                       dn_rvalid,
    output logic [ARR_N:0]                       dn_rready,
    input  logic [(ARR_N+1)*DW-1:0]              dn_rdata,
    input  logic [2*ARR_N+1:0]                   dn_rresp
);
    localparam int NC      = ARR_N + 1;
    localparam int IW      = $clog2(NC + 1);
    localparam int SOLO_AW = $clog2(SOLO_SIZE);
    localparam int ARR_AW  = $clog2(ARR_STRIDE);

    logic [IW-1:0] wr_hit, rd_hit;

    // fields that every child may see; the valids gate their meaning
    assign dn_awprot = up_awprot;
    assign dn_arprot = up_arprot;
    assign dn_wdata  = up_wdata;
    assign dn_wstrb  = up_wstrb;

    axil_split_decode #(
        .AW(AW), .SOLO_BASE(SOLO_BASE), .SOLO_SIZE(SOLO_SIZE),
        .ARR_BASE(ARR_BASE), .ARR_STRIDE(ARR_STRIDE), .ARR_N(ARR_N),
        .IW(IW), .SOLO_AW(SOLO_AW), .ARR_AW(ARR_AW)
    ) u_wdec (
        .addr(up_awaddr), .hit_idx(wr_hit),
        .solo_addr(solo_awaddr), .tile_addr(tile_awaddr)
    );

    axil_split_decode #(
        .AW(AW), .SOLO_BASE(SOLO_BASE), .SOLO_SIZE(SOLO_SIZE),
        .ARR_BASE(ARR_BASE), .ARR_STRIDE(ARR_STRIDE), .ARR_N(ARR_N),
        .IW(IW), .SOLO_AW(SOLO_AW), .ARR_AW(ARR_AW)
    ) u_rdec (
        .addr(up_araddr), .hit_idx(rd_hit),
        .solo_addr(solo_araddr), .tile_addr(tile_araddr)
    );

    axil_split_wr #(.NC(NC), .IW(IW)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .up_awvalid(up_awvalid), .up_awready(up_awready),
        .up_wvalid(up_wvalid), .up_wready(up_wready),
        .up_bvalid(up_bvalid), .up_bready(up_bready), .up_bresp(up_bresp),
        .hit_idx(wr_hit),
        .dn_awvalid(dn_awvalid), .dn_awready(dn_awready),
        .dn_wvalid(dn_wvalid), .dn_wready(dn_wready),
        .dn_bvalid(dn_bvalid), .dn_bready(dn_bready), .dn_bresp(dn_bresp)
    );

    axil_split_rd #(.NC(NC), .IW(IW), .DW(DW)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .up_arvalid(up_arvalid), .up_arready(up_arready),
        .up_rvalid(up_rvalid), .up_rready(up_rready),
        .up_rdata(up_rdata), .up_rresp(up_rresp),
        .hit_idx(rd_hit),
        .dn_arvalid(dn_arvalid), .dn_arready(dn_arready),
        .dn_rvalid(dn_rvalid), .dn_rready(dn_rready),
        .dn_rdata(dn_rdata), .dn_rresp(dn_rresp)
    );

    a_r10_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!up_bvalid && !up_rvalid && dn_awvalid == '0 && dn_arvalid == '0));

endmodule

// File: tb/sim_axil_split.sv
module sim_axil_split;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int SW = DW / 8;
    localparam int ARR_N = 4;
    localparam int NC = ARR_N + 1;
    localparam int SOLO_BASE = 32'h1000;
    localparam int SOLO_SIZE = 256;
    localparam int ARR_BASE = 32'h2000;
    localparam int ARR_STRIDE = 64;
    localparam int SOLO_AW = 8;
    localparam int ARR_AW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_awvalid = 0, up_wvalid = 0, up_bready = 0, up_arvalid = 0, up_rready = 0;
    logic up_awready, up_wready, up_bvalid, up_arready, up_rvalid;
    logic [AW-1:0] up_awaddr = '0, up_araddr = '0;
    logic [2:0] up_awprot = '0, up_arprot = '0;
    logic [DW-1:0] up_wdata = '0;
    logic [SW-1:0] up_wstrb = '0;
    logic [1:0] up_bresp, up_rresp;
    logic [DW-1:0] up_rdata;
    logic [NC-1:0] dn_awvalid, dn_wvalid, dn_bready, dn_arvalid, dn_rready;
    logic [NC-1:0] aw_rdy = '1, w_rdy = '1, ar_rdy = '1;
    logic [NC-1:0] bv, rv, awg, wg;
    logic [SOLO_AW-1:0] solo_awaddr, solo_araddr;
    logic [ARR_N*ARR_AW-1:0] tile_awaddr, tile_araddr;
    logic [2:0] dn_awprot, dn_arprot;
    logic [DW-1:0] dn_wdata;
    logic [SW-1:0] dn_wstrb;
    logic [2*NC-1:0] dn_bresp, dn_rresp;
    logic [NC*DW-1:0] dn_rdata;
    logic [DW-1:0] rdat [NC];
    int wcount [NC];

    int checks = 0;
    int errors = 0;
    int exp_wch = -2;
    int exp_rch = -2;
    bit done = 0;

    axil_split #(
        .AW(AW), .DW(DW), .SOLO_BASE(SOLO_BASE), .SOLO_SIZE(SOLO_SIZE),
        .ARR_BASE(ARR_BASE), .ARR_STRIDE(ARR_STRIDE), .ARR_N(ARR_N)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .up_awvalid(up_awvalid), .up_awready(up_awready), .up_awaddr(up_awaddr), .up_awprot(up_awprot),
        .up_wvalid(up_wvalid), .up_wready(up_wready), .up_wdata(up_wdata), .up_wstrb(up_wstrb),
        .up_bvalid(up_bvalid), .up_bready(up_bready), .up_bresp(up_bresp),
        .up_arvalid(up_arvalid), .up_arready(up_arready), .up_araddr(up_araddr), .up_arprot(up_arprot),
        .up_rvalid(up_rvalid), .up_rready(up_rready), .up_rdata(up_rdata), .up_rresp(up_rresp),
        .dn_awvalid(dn_awvalid), .dn_awready(aw_rdy), .solo_awaddr(solo_awaddr), .tile_awaddr(tile_awaddr),
        .dn_awprot(dn_awprot), .dn_wvalid(dn_wvalid), .dn_wready(w_rdy), .dn_wdata(dn_wdata),
        .dn_wstrb(dn_wstrb), .dn_bvalid(bv), .dn_bready(dn_bready), .dn_bresp(dn_bresp),
        .dn_arvalid(dn_arvalid), .dn_arready(ar_rdy), .solo_araddr(solo_araddr), .tile_araddr(tile_araddr),
        .dn_arprot(dn_arprot), .dn_rvalid(rv), .dn_rready(dn_rready), .dn_rdata(dn_rdata), .dn_rresp(dn_rresp)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [1:0] resp_of(int c);
        return (c % 2 == 1) ? 2'b10 : 2'b00;
    endfunction

    function automatic logic [DW-1:0] pattern(int c, int off);
        return {8'hA5, 8'(c), 16'(off)};
    endfunction

    // expected target and local offset, from the address windows alone
    task automatic map_addr(input int a, output int ch, output int off);
        ch = -1; off = 0;
        if (a >= SOLO_BASE && a < SOLO_BASE + SOLO_SIZE) begin
            ch = 0; off = a - SOLO_BASE;
        end else if (a >= ARR_BASE && a < ARR_BASE + ARR_N * ARR_STRIDE) begin
            ch = 1 + (a - ARR_BASE) / ARR_STRIDE; off = (a - ARR_BASE) % ARR_STRIDE;
        end
    endtask

    function automatic int ch_aw(int c);
        if (c == 0) return int'(solo_awaddr);
        return int'(tile_awaddr[(c-1)*ARR_AW +: ARR_AW]);
    endfunction

    function automatic int ch_ar(int c);
        if (c == 0) return int'(solo_araddr);
        return int'(tile_araddr[(c-1)*ARR_AW +: ARR_AW]);
    endfunction

    function automatic logic [NC-1:0] mask_of(int c);
        return (c >= 0) ? NC'(1) << c : '0;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    for (genvar c = 0; c < NC; c++) begin : g_resp
        assign dn_bresp[2*c +: 2] = resp_of(c);
        assign dn_rresp[2*c +: 2] = resp_of(c);
        assign dn_rdata[c*DW +: DW] = rdat[c];
    end

    // behavioural children: answer one cycle after accepting a request
    always @(posedge clk) begin
        if (!rst_n) begin
            awg <= '0; wg <= '0; bv <= '0; rv <= '0;
            for (int c = 0; c < NC; c++) begin wcount[c] <= 0; rdat[c] <= '0; end
        end else begin
            for (int c = 0; c < NC; c++) begin
                if (dn_awvalid[c] && aw_rdy[c]) awg[c] <= 1'b1;
                if (dn_wvalid[c] && w_rdy[c]) wg[c] <= 1'b1;
                if (awg[c] && wg[c] && !bv[c]) begin
                    bv[c] <= 1'b1; awg[c] <= 1'b0; wg[c] <= 1'b0; wcount[c] <= wcount[c] + 1;
                end
                if (bv[c] && dn_bready[c]) bv[c] <= 1'b0;
                if (dn_arvalid[c] && ar_rdy[c]) begin rv[c] <= 1'b1; rdat[c] <= pattern(c, ch_ar(c)); end
                if (rv[c] && dn_rready[c]) rv[c] <= 1'b0;
            end
        end
    end

    // per-clock comparison with the bench's expected targets
    always @(negedge clk) begin
        if (rst_n) begin
            #2;
            check((dn_awvalid & ~mask_of(exp_wch)) == '0, "R5", "stray write valid", dn_awvalid, mask_of(exp_wch));
            check((dn_arvalid & ~mask_of(exp_rch)) == '0, "R5", "stray read valid", dn_arvalid, mask_of(exp_rch));
        end
    end

    task automatic do_write(input int a, input logic [DW-1:0] d, input logic [SW-1:0] s,
                            input logic [2:0] p, input int bwait);
        int ch, off, total_before, total_after, mine_before;
        bit awp, wp, awh, wh, got;
        map_addr(a, ch, off);
        total_before = 0;
        for (int c = 0; c < NC; c++) total_before += wcount[c];
        mine_before = (ch >= 0) ? wcount[ch] : 0;
        awp = 1; wp = 1;
        @(negedge clk);
        up_awaddr = AW'(a); up_awprot = p; up_awvalid = 1;
        up_wdata = d; up_wstrb = s; up_wvalid = 1;
        exp_wch = ch;
        while (awp || wp) begin
            #1;
            awh = awp && up_awready;
            wh  = wp && up_wready;
            if (awh && ch >= 0) begin
                check(dn_awvalid == mask_of(ch), ch == 0 ? "R1" : "R2", "write target", dn_awvalid, mask_of(ch));
                check(ch_aw(ch) == off, ch == 0 ? "R1" : "R2", "rebased write address", ch_aw(ch), off);
                check(dn_awprot == p, "R4", "write prot", dn_awprot, p);
            end
            if (wh && ch >= 0) begin
                check(dn_wvalid == mask_of(ch), "R4", "write data valid", dn_wvalid, mask_of(ch));
                check(dn_wdata == d && dn_wstrb == s, "R4", "write data/strobe", {dn_wstrb, dn_wdata}, {s, d});
            end
            @(negedge clk);
            if (awh) begin up_awvalid = 0; awp = 0; end
            if (wh)  begin up_wvalid = 0; wp = 0; end
        end
        // hold response ready low and offer a second request: must not be taken
        for (int k = 0; k < bwait; k++) begin
            up_awaddr = AW'(SOLO_BASE + 16); up_awvalid = 1; up_wvalid = 1;
            #1;
            check(!up_awready && !up_wready, "R9", "accept while response pending",
                  {up_awready, up_wready}, 0);
            @(negedge clk);
            up_awvalid = 0; up_wvalid = 0;
        end
        up_bready = 1;
        got = 0;
        while (!got) begin
            #1;
            if (up_bvalid) begin
                got = 1;
                check(up_bresp == ((ch < 0) ? 2'b11 : resp_of(ch)), ch < 0 ? "R8" : "R7",
                      "write response", up_bresp, (ch < 0) ? 2'b11 : resp_of(ch));
            end
            @(negedge clk);
        end
        up_bready = 0;
        exp_wch = -2;
        total_after = 0;
        for (int c = 0; c < NC; c++) total_after += wcount[c];
        check(total_after == total_before + ((ch >= 0) ? 1 : 0), ch < 0 ? "R8" : "R5",
              "children written", total_after - total_before, (ch >= 0) ? 1 : 0);
        if (ch >= 0)
            check(wcount[ch] == mine_before + 1, "R7", "owner completed", wcount[ch], mine_before + 1);
    endtask

    task automatic do_read(input int a, input logic [2:0] p);
        int ch, off;
        bit arh, got;
        logic [DW-1:0] expd;
        map_addr(a, ch, off);
        expd = (ch < 0) ? '0 : pattern(ch, off);
        @(negedge clk);
        up_araddr = AW'(a); up_arprot = p; up_arvalid = 1;
        exp_rch = ch;
        arh = 0;
        while (!arh) begin
            #1;
            arh = up_arready;
            if (arh && ch >= 0) begin
                check(dn_arvalid == mask_of(ch), "R3", "read target", dn_arvalid, mask_of(ch));
                check(ch_ar(ch) == off, "R3", "rebased read address", ch_ar(ch), off);
                check(dn_arprot == p, "R4", "read prot", dn_arprot, p);
            end
            @(negedge clk);
        end
        up_arvalid = 0;
        up_rready = 1;
        got = 0;
        while (!got) begin
            #1;
            if (up_rvalid) begin
                got = 1;
                check(up_rdata == expd, ch < 0 ? "R8" : "R7", "read data", up_rdata, expd);
                check(up_rresp == ((ch < 0) ? 2'b11 : resp_of(ch)), ch < 0 ? "R8" : "R7",
                      "read response", up_rresp, (ch < 0) ? 2'b11 : resp_of(ch));
            end
            @(negedge clk);
        end
        up_rready = 0;
        exp_rch = -2;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(!up_awready && !up_wready && !up_arready && !up_bvalid && !up_rvalid,
              "R10", "upstream idle in reset", {up_awready, up_wready, up_arready, up_bvalid, up_rvalid}, 0);
        check(dn_awvalid == '0 && dn_arvalid == '0 && dn_wvalid == '0, "R10", "children idle in reset",
              {dn_awvalid, dn_arvalid}, 0);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #1;
        check(!up_bvalid && !up_rvalid && dn_awvalid == '0, "R10", "idle after reset",
              {up_bvalid, up_rvalid, dn_awvalid}, 0);

        // R1: solo region at its edges
        do_write(SOLO_BASE, 32'h1111_2222, 4'hF, 3'd5, 0);
        do_write(SOLO_BASE + SOLO_SIZE - 4, 32'hCAFE_0001, 4'h3, 3'd2, 0);
        // R2: first and last word of every tile
        for (int i = 0; i < ARR_N; i++) begin
            do_write(ARR_BASE + i * ARR_STRIDE, 32'h100 + i, 4'h1, 3'(i), 0);
            do_write(ARR_BASE + i * ARR_STRIDE + ARR_STRIDE - 4, 32'h200 + i, 4'h8, 3'd7, 0);
        end
        // R3: reads through the same windows
        do_read(SOLO_BASE + 8'h40, 3'd1);
        do_read(ARR_BASE + ARR_STRIDE + 8'h3C, 3'd6);
        do_read(ARR_BASE + 3 * ARR_STRIDE, 3'd0);
        // R8: unmapped addresses on both sides of each window
        do_write(SOLO_BASE - 4, 32'hDEAD_0000, 4'hF, 3'd0, 0);
        do_write(ARR_BASE + ARR_N * ARR_STRIDE, 32'hDEAD_0001, 4'hF, 3'd0, 0);
        do_read(SOLO_BASE + SOLO_SIZE, 3'd0);
        do_read(32'h3000, 3'd0);
        // R9: response held back while a new request waits
        do_write(ARR_BASE + 2 * ARR_STRIDE + 8, 32'h5A5A_5A5A, 4'hF, 3'd3, 3);
        // R3: concurrent write and read to different children
        fork
            do_write(ARR_BASE + 16, 32'h7777_0000, 4'hC, 3'd4, 0);
            do_read(ARR_BASE + 2 * ARR_STRIDE + 20, 3'd2);
        join
        // R6: one-cycle latch delay, then a stalled child holds off the handshake
        aw_rdy[2] = 1'b0;
        fork
            do_write(ARR_BASE + ARR_STRIDE + 4, 32'h6666_0000, 4'hF, 3'd1, 0);
            begin
                @(negedge clk);
                #2;
                check(dn_awvalid == '0, "R6", "valid before latch cycle", dn_awvalid, 0);
                @(negedge clk);
                #2;
                check(dn_awvalid == 5'b00100, "R6", "valid after latch cycle", dn_awvalid, 5'b00100);
                repeat (3) begin
                    @(negedge clk);
                    #2;
                    check(!up_awready && dn_awvalid[2], "R6", "stall follows child ready",
                          {up_awready, dn_awvalid[2]}, 2'b01);
                end
                @(negedge clk);
                aw_rdy[2] = 1'b1;
            end
        join
        ar_rdy[0] = 1'b0;
        fork
            do_read(SOLO_BASE + 4, 3'd0);
            begin
                repeat (3) @(negedge clk);
                #2;
                check(!up_arready && dn_arvalid[0], "R6", "read stall follows child ready",
                      {up_arready, dn_arvalid[0]}, 2'b01);
                @(negedge clk);
                ar_rdy[0] = 1'b1;
            end
        join

        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule